// File: doc/BRIEF.md
# Serial Port Bit Clock and Frame Sync Generator

This block produces all the timing a synchronous serial data port needs, using only the core clock. A chain of three dividers sets the bit rate. The first is a prescaler that divides by one or by eight. The second is an 8-bit modulus divider. The third is a fixed halving stage. Each section of the port, transmit and receive, then counts bits into words of a selectable length and counts words into frames of a selectable size. It also produces a frame sync level that is either one bit or one word long.

Every output is a single-cycle enable or a level in the core clock domain; no derived clock leaves the block. In synchronous mode the receive outputs copy the transmit timing. In asynchronous mode the receive section counts words and frames with its own word-length and frame-size settings, on the same bit clock. A new divide setting does not take effect when it is written. Each section loads it at its own next frame boundary, so a frame in progress is never cut short.

Top module: `sclk_fsync_gen`

## Requirements
- R1: `bit_en` pulses once every P*(M+1)*2 core cycles, where P is 8 when `pre_div8` is 1 and 1 otherwise, and M is `bit_mod`. The first pulse comes in the (P*(M+1)*2)-th cycle after reset is released. Two pulses are never on adjacent cycles.
- R2: `cfg_illegal` is 1 exactly when `pre_div8` is 0 and `bit_mod` is 0, which is a total divide of 2. It follows the inputs in the same cycle.
- R3: `tx_word_stb` pulses together with every W-th `bit_en`. W comes from `tx_wl_code`: 0 gives 8, 1 gives 12, 2 gives 16, 3 gives 24, and 4 to 7 give 32.
- R4: A transmit frame holds D+1 words, where D is `tx_frm_len` (0 to 31). When `fs_word` is 0, `tx_fsync` is high during the first bit period of each frame.
- R5: When `fs_word` is 1, the frame sync is high for the whole first word of each frame.
- R6: When `sync_mode` is 1, `rx_word_stb` and `rx_fsync` are identical to `tx_word_stb` and `tx_fsync`.
- R7: When `sync_mode` is 0, the receive outputs follow the R3 to R5 rules with `rx_wl_code` and `rx_frm_len`, counted independently from reset.
- R8: A change to `pre_div8`, `bit_mod`, the word-length codes, the frame sizes, `fs_word` or `sync_mode` takes effect at the next frame boundary of that section; the transmit boundary governs the bit-clock settings and the mode. Settings present during reset apply from the first cycle after reset.
- R9: While `rst_n` is low, `bit_en` and the word strobes are 0, and every counter is held at zero, so the frame sync levels are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pre_div8 | input | 1 | Prescaler select: 1 divides by 8, 0 passes through |
| bit_mod | input | 8 | Modulus M; divides by M+1 |
| tx_wl_code | input | 3 | Transmit word-length code |
| tx_frm_len | input | 5 | Transmit words per frame minus one |
| rx_wl_code | input | 3 | Receive word-length code (asynchronous mode) |
| rx_frm_len | input | 5 | Receive words per frame minus one (asynchronous mode) |
| sync_mode | input | 1 | 1 merges the receive timing into the transmit timing |
| fs_word | input | 1 | Frame sync length: 1 is one word, 0 is one bit |
| bit_en | output | 1 | Bit clock enable strobe |
| tx_word_stb | output | 1 | Transmit word strobe |
| tx_fsync | output | 1 | Transmit frame sync level |
| rx_word_stb | output | 1 | Receive word strobe |
| rx_fsync | output | 1 | Receive frame sync level |
| cfg_illegal | output | 1 | Divide-by-two configuration flag |

## Verification
The bench sweeps every word-length code, several frame sizes and both sync lengths against an arithmetic timing model. A wrong code map or an off-by-one counter then shows up as a shifted word strobe or a sync pulse of the wrong length. Pairing mismatched transmit and receive settings catches a receive section that wrongly follows the transmit counters, or the reverse. A mid-frame rewrite of the modulus, the word length and the frame size checks that a design which applies settings at once fails: it would cut the current frame short and shift every later pulse. The divide-by-two configuration is run to confirm the flag, and that strobes still never fall on adjacent cycles.

// File: rtl/sfg_pkg.sv
// Package: shared widths and the word-length decode for the serial
// timing generator. Assumes word lengths never exceed 32 bits.
package sfg_pkg;
    localparam int MOD_W   = 8;
    localparam int WLC_W   = 3;
    localparam int FRM_W   = 5;
    localparam int PRE_DIV = 8;
    localparam int BIT_CW  = 5;

    // Last bit index of a word for a given length code.
    function automatic logic [BIT_CW-1:0] wl_last(input logic [WLC_W-1:0] code);
        case (code)
            3'd0:    wl_last = 5'd7;
            3'd1:    wl_last = 5'd11;
            3'd2:    wl_last = 5'd15;
            3'd3:    wl_last = 5'd23;
            default: wl_last = 5'd31;
        endcase
    endfunction
endpackage

// File: rtl/sfg_bitclk.sv
// Bit clock enable: prescaler (1 or PRE_DIV), modulus divider (M+1) and a
// fixed halving stage. Settings are loaded during reset and on 'load',
// which must coincide with a bit_en so every counter is already at zero.
module sfg_bitclk #(
    parameter int MOD_W   = 8,
    parameter int PRE_DIV = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             slow_in,
    input  logic [MOD_W-1:0] mod_in,
    output logic             bit_en
);
    localparam int PRE_CW = $clog2(PRE_DIV);

    logic [PRE_CW-1:0] pre_cnt;
    logic [MOD_W-1:0]  mod_cnt;
    logic [MOD_W-1:0]  act_mod;
    logic              act_slow;
    logic              half;
    logic              pre_tick;
    logic              mod_tick;

    assign pre_tick = !act_slow || (pre_cnt == PRE_CW'(PRE_DIV - 1));
    assign mod_tick = pre_tick && (mod_cnt == act_mod);
    assign bit_en   = mod_tick && half;

    // Advance the three divide stages and pick up new settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            mod_cnt  <= '0;
            half     <= 1'b0;
            act_slow <= slow_in;
            act_mod  <= mod_in;
        end else begin
            if (!act_slow || pre_tick) pre_cnt <= '0;
            else                       pre_cnt <= pre_cnt + 1'b1;
            if (mod_tick)      mod_cnt <= '0;
            else if (pre_tick) mod_cnt <= mod_cnt + 1'b1;
            if (mod_tick) half <= ~half;
            if (load) begin
                act_slow <= slow_in;
                act_mod  <= mod_in;
            end
        end
    end
endmodule

// File: rtl/sfg_framer.sv
// Word and frame counter for one port section. Counts bit enables into
// words, words into frames, and drives a frame sync level one bit or one
// word long. Settings load during reset and at the section's frame end.
module sfg_framer #(
    parameter int WLC_W = 3,
    parameter int FRM_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic [WLC_W-1:0] wl_code_in,
    input  logic [FRM_W-1:0] frm_in,
    input  logic             fs_word_in,
    output logic             word_stb,
    output logic             frame_end,
    output logic             fsync
);
    import sfg_pkg::*;

    logic [BIT_CW-1:0] bit_cnt;
    logic [FRM_W-1:0]  word_cnt;
    logic [WLC_W-1:0]  act_code;
    logic [FRM_W-1:0]  act_frm;
    logic              act_fsw;

    assign word_stb  = bit_en && (bit_cnt == wl_last(act_code));
    assign frame_end = word_stb && (word_cnt == act_frm);
    assign fsync     = (word_cnt == '0) && (act_fsw || bit_cnt == '0);

    // Count bits and words; reload settings at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            word_cnt <= '0;
            act_code <= wl_code_in;
            act_frm  <= frm_in;
            act_fsw  <= fs_word_in;
        end else begin
            if (word_stb)    bit_cnt <= '0;
            else if (bit_en) bit_cnt <= bit_cnt + 1'b1;
            if (frame_end)     word_cnt <= '0;
            else if (word_stb) word_cnt <= word_cnt + 1'b1;
            if (frame_end) begin
                act_code <= wl_code_in;
                act_frm  <= frm_in;
                act_fsw  <= fs_word_in;
            end
        end
    end
endmodule

// File: rtl/sclk_fsync_gen.sv
// Top: shared bit clock plus a transmit and a receive framer. In sync
// mode the receive outputs mirror the transmit section. The bit clock
// settings and the mode load at the transmit frame boundary.
module sclk_fsync_gen #(
    parameter int MOD_W   = sfg_pkg::MOD_W,
    parameter int WLC_W   = sfg_pkg::WLC_W,
    parameter int FRM_W   = sfg_pkg::FRM_W,
    parameter int PRE_DIV = sfg_pkg::PRE_DIV
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_div8,
    input  logic [MOD_W-1:0] bit_mod,
    input  logic [WLC_W-1:0] tx_wl_code,
    input  logic [FRM_W-1:0] tx_frm_len,
    input  logic [WLC_W-1:0] rx_wl_code,
    input  logic [FRM_W-1:0] rx_frm_len,
    input  logic             sync_mode,
    input  logic             fs_word,
    output logic             bit_en,
    output logic             tx_word_stb,
    output logic             tx_fsync,
    output logic             rx_word_stb,
    output logic             rx_fsync,
    output logic             cfg_illegal
);
    localparam int NSEC = 2;

    logic [WLC_W-1:0] sec_code [NSEC];
    logic [FRM_W-1:0] sec_frm  [NSEC];
    logic [NSEC-1:0]  sec_word;
    logic [NSEC-1:0]  sec_end;
    logic [NSEC-1:0]  sec_fs;
    logic             act_sync;

    assign sec_code[0] = tx_wl_code;
    assign sec_code[1] = rx_wl_code;
    assign sec_frm[0]  = tx_frm_len;
    assign sec_frm[1]  = rx_frm_len;

    sfg_bitclk #(.MOD_W(MOD_W), .PRE_DIV(PRE_DIV)) u_bclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sec_end[0]),
        .slow_in (pre_div8),
        .mod_in  (bit_mod),
        .bit_en  (bit_en)
    );

    for (genvar s = 0; s < NSEC; s++) begin : g_sec
        sfg_framer #(.WLC_W(WLC_W), .FRM_W(FRM_W)) u_frm (
            .clk        (clk),
            .rst_n      (rst_n),
            .bit_en     (bit_en),
            .wl_code_in (sec_code[s]),
            .frm_in     (sec_frm[s]),
            .fs_word_in (fs_word),
            .word_stb   (sec_word[s]),
            .frame_end  (sec_end[s]),
            .fsync      (sec_fs[s])
        );
    end

    // Latch the sync/async mode at the transmit frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)          act_sync <= sync_mode;
        else if (sec_end[0]) act_sync <= sync_mode;
    end

    assign tx_word_stb = sec_word[0];
    assign tx_fsync    = sec_fs[0];
    assign rx_word_stb = act_sync ? sec_word[0] : sec_word[1];
    assign rx_fsync    = act_sync ? sec_fs[0]   : sec_fs[1];
    assign cfg_illegal = !pre_div8 && (bit_mod == '0);
endmodule

// File: rtl/sfg_checker.sv
// Checker: timing properties of the generator outputs, bound to the top.
module sfg_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic tx_word_stb,
    input logic tx_fsync,
    input logic rx_word_stb
);
    // R1: bit strobes never fall on adjacent cycles.
    p_bit_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |=> !bit_en);
    // R3: a transmit word ends only on a bit strobe.
    p_tx_word_on_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_word_stb |-> bit_en);
    // R7: a receive word ends only on a bit strobe.
    p_rx_word_on_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_word_stb |-> bit_en);
    // R4: the transmit sync rises only right after a word boundary.
    p_fs_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_fsync) |-> $past(tx_word_stb));
    // R5: the transmit sync drops only right after a bit strobe.
    p_fs_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_fsync) |-> $past(bit_en));
endmodule

bind sclk_fsync_gen sfg_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .tx_word_stb (tx_word_stb),
    .tx_fsync    (tx_fsync),
    .rx_word_stb (rx_word_stb)
);

// File: tb/tb_sclk_fsync_gen.sv
// Bench: configuration sweep against an arithmetic timing model.
module tb_sclk_fsync_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pre_div8 = 1'b0;
    logic [7:0] bit_mod = 8'd1;
    logic [2:0] tx_wl_code = '0, rx_wl_code = '0;
    logic [4:0] tx_frm_len = '0, rx_frm_len = '0;
    logic       sync_mode = 1'b1, fs_word = 1'b0;
    logic       bit_en, tx_word_stb, tx_fsync, rx_word_stb, rx_fsync, cfg_illegal;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sclk_fsync_gen dut (.*);

    function automatic int wl_of(input int code);
        case (code)
            0: return 8;
            1: return 12;
            2: return 16;
            3: return 24;
            default: return 32;
        endcase
    endfunction

    // Expected {bit, word, sync} at cycle t of a run with divide n.
    function automatic logic [2:0] model(input int t, input int n, input int wl,
                                         input int d, input bit fw);
        int fr;
        fr = t % (n * wl * (d + 1));
        model[2] = ((t + 1) % n) == 0;
        model[1] = ((t + 1) % (n * wl)) == 0;
        model[0] = fw ? (fr < n * wl) : (fr < n);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Reset with a configuration, then compare every cycle for two frames.
    task automatic run_cfg(input bit dv8, input int m, input int twl, input int td,
                           input int rwl, input int rd, input bit fw, input bit sy);
        int n, tl, rl, T, bad_b, bad_tw, bad_tf, bad_rw, bad_rf;
        logic [2:0] et, er;
        @(negedge clk);
        rst_n = 1'b0;
        pre_div8 = dv8; bit_mod = 8'(m);
        tx_wl_code = 3'(twl); tx_frm_len = 5'(td);
        rx_wl_code = 3'(rwl); rx_frm_len = 5'(rd);
        fs_word = fw; sync_mode = sy;
        @(negedge clk); @(negedge clk);
        #1;
        check(!bit_en && !tx_word_stb && tx_fsync && rx_fsync, "R9", "reset outputs",
              {bit_en, tx_word_stb, tx_fsync, rx_fsync}, 4'b0011);
        check(cfg_illegal == (!dv8 && m == 0), "R2", "illegal flag", cfg_illegal, !dv8 && m == 0);
        @(negedge clk);
        rst_n = 1'b1;
        n  = (dv8 ? 8 : 1) * (m + 1) * 2;
        tl = n * wl_of(twl) * (td + 1);
        rl = sy ? tl : n * wl_of(rwl) * (rd + 1);
        T  = 2 * ((tl > rl) ? tl : rl);
        bad_b = -1; bad_tw = -1; bad_tf = -1; bad_rw = -1; bad_rf = -1;
        for (int t = 0; t < T; t++) begin
            #1;
            et = model(t, n, wl_of(twl), td, fw);
            er = sy ? et : model(t, n, wl_of(rwl), rd, fw);
            if (bit_en != et[2] && bad_b < 0) bad_b = t;
            if (tx_word_stb != et[1] && bad_tw < 0) bad_tw = t;
            if (tx_fsync != et[0] && bad_tf < 0) bad_tf = t;
            if (rx_word_stb != er[1] && bad_rw < 0) bad_rw = t;
            if (rx_fsync != er[0] && bad_rf < 0) bad_rf = t;
            @(negedge clk);
        end
        check(bad_b < 0, "R1", "bit strobe first bad cycle", bad_b, -1);
        check(bad_tw < 0, "R3", "tx word strobe first bad cycle", bad_tw, -1);
        check(bad_tf < 0, fw ? "R5" : "R4", "tx sync first bad cycle", bad_tf, -1);
        check(bad_rw < 0, sy ? "R6" : "R7", "rx word strobe first bad cycle", bad_rw, -1);
        check(bad_rf < 0, sy ? "R6" : "R7", "rx sync first bad cycle", bad_rf, -1);
    endtask

    // R8: rewrite settings mid-frame; old timing must finish the frame.
    task automatic run_change();
        int bad;
        logic [2:0] e;
        run_cfg(1'b0, 1, 0, 1, 0, 1, 1'b0, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        bad = -1;
        for (int t = 0; t < 64 + 64; t++) begin
            #1;
            if (t < 64) e = model(t, 4, 8, 1, 1'b0);
            else        e = model(t - 64, 2, 16, 0, 1'b1);
            if ({bit_en, tx_word_stb, tx_fsync} != e && bad < 0) bad = t;
            if (t == 21) check(cfg_illegal == 1'b1, "R2", "flag follows input", cfg_illegal, 1);
            if (t == 20) begin
                bit_mod = 8'd0; tx_wl_code = 3'd2; tx_frm_len = 5'd0; fs_word = 1'b1;
            end
            @(negedge clk);
        end
        check(bad < 0, "R8", "change at frame boundary first bad cycle", bad, -1);
    endtask

    initial begin
        for (int m = 0; m < 2; m++)
            for (int wl = 0; wl < 8; wl++)
                for (int d = 0; d < 3; d++)
                    for (int fw = 0; fw < 2; fw++)
                        run_cfg(1'b0, m, wl, d, (wl + 3) % 8, (d + 1) % 3,
                                fw[0], ((wl + d + m) % 2) == 0);
        run_cfg(1'b1, 0, 0, 1, 1, 0, 1'b0, 1'b0);
        run_cfg(1'b1, 2, 0, 1, 2, 0, 1'b1, 1'b1);
        run_change();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog run did not complete");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule